// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer Core

This block is a 32-bit up-counter. It advances on a functional clock enable, either at full rate or through a power-of-two prescaler. When the count steps past its all-ones value, the counter either reloads from a load register and keeps running, or clears to zero and drops its own start bit. A compare stage can raise a one-cycle pulse when the count reaches a programmed match value. Each advance past all-ones also gives a one-cycle overflow pulse.

Software-facing logic sits outside this core. That logic writes the control word, the load value and the match value through simple write-enable ports. It can also overwrite the count directly, or fire a reload strobe that copies the load value into the count at once. The core's outputs are the live count, the present control word (which shows the self-cleared start bit) and the two event pulses. A separate interrupt layer turns the pulses into interrupts.

Top module: `rtimer_top`

## Requirements
- R1: After reset, the count, the control word, the load value and the match value are all zero, and both pulses are low.
- R2: With start (control bit 0) set and the prescaler enable (control bit 5) clear, the count rises by one in each cycle that `tick_en` is high. In a cycle with `tick_en` low, the count holds.
- R3: While start is clear, the count holds its value and neither pulse is raised.
- R4: With the prescaler enable set, the count advances once per 2^(ratio+1) enabled ticks, where the ratio is control bits 4:2. The first advance comes on the 2^(ratio+1)-th tick after the prescaler restarts.
- R5: When an advance steps past 0xFFFFFFFF with auto-reload (control bit 1) set, the count takes the load value. Start stays set, and `ovf_pulse` is high for that one cycle.
- R6: When an advance steps past 0xFFFFFFFF with auto-reload clear, the count becomes 0, start clears by itself, and `ovf_pulse` is high for one cycle. Afterwards the count stays at 0.
- R7: With compare enable (control bit 6) set, `match_pulse` is high for exactly the cycle in which an advance brings the count to the match value. With compare enable clear, no match pulse is raised.
- R8: If one advance both overflows and lands on the match value, both pulses are high in the same cycle.
- R9: A reload strobe copies the load value into the count on the next edge. A direct count write replaces the count with the written value. A count write takes priority over a reload strobe, and both take priority over an advance.
- R10: The prescaler phase restarts from zero on a count write, on a reload strobe, and whenever start is clear.
- R11: The control word written through `ctl_we` is held and shown unchanged on `ctl_q`. Its bit layout is: 0 start, 1 auto-reload, 4:2 ratio, 5 prescaler enable, 6 compare enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Functional clock enable; one tick per high cycle |
| ctl_we | input | 1 | Control word write enable |
| ctl_wd | input | 7 | Control word write data |
| ld_we | input | 1 | Load value write enable |
| ld_wd | input | COUNT_W | Load value write data |
| mat_we | input | 1 | Match value write enable |
| mat_wd | input | COUNT_W | Match value write data |
| cnt_we | input | 1 | Direct count write enable |
| cnt_wd | input | COUNT_W | Direct count write data |
| reload_stb | input | 1 | Copy load value into the count |
| count | output | COUNT_W | Live count |
| ctl_q | output | 7 | Present control word |
| ovf_pulse | output | 1 | One-cycle overflow event |
| match_pulse | output | 1 | One-cycle compare-match event |

## Verification
A bad prescaler phase shows up within one divide period: the count steps early or late against the tick count the bench predicts, and a missed phase restart after a count write shifts the next step by up to 2^(ratio+1) ticks. A wrong wrap decision shows up in the cycle right after the all-ones count. That cycle exposes the count value, the start bit on `ctl_q` and both pulses together. A compare that looks at the old count instead of the new one makes the match pulse one cycle late, and the bench samples each pulse in the single cycle where it must appear.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;
   localparam int CTL_W     = 7;
   localparam int RATIO_W   = 3;
   localparam int B_START   = 0;
   localparam int B_RELOAD  = 1;
   localparam int B_PSC_EN  = 5;
   localparam int B_CMP_EN  = 6;

   // field order follows the control word bit layout (MSB first)
   typedef struct packed {
      logic               cmp_en;
      logic               psc_en;
      logic [RATIO_W-1:0] ratio;
      logic               reload;
      logic               start;
   } ctl_t;
endpackage

// File: rtl/rtimer_psc.sv
module rtimer_psc #(
   parameter int RATIO_W = 3,
   parameter bit HAS_PSC = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_en,
   input  logic               run,
   input  logic               restart,
   input  logic               psc_en,
   input  logic [RATIO_W-1:0] ratio,
   output logic               adv
);
   localparam int PSC_W = 2 ** RATIO_W;
   localparam logic [PSC_W-1:0] ONES = {PSC_W{1'b1}};
   localparam logic [RATIO_W-1:0] TOP_R = RATIO_W'(PSC_W - 1);

   generate
      if (HAS_PSC) begin : g_psc
         logic [PSC_W-1:0] phase;
         logic [PSC_W-1:0] term;
         logic             at_term;

         assign term    = ONES >> (TOP_R - ratio);
         assign at_term = (phase == term);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase <= '0;
            end else if (restart || !psc_en) begin
               phase <= '0;
            end else if (tick_en && run) begin
               phase <= at_term ? '0 : phase + 1'b1;
            end
         end

         assign adv = tick_en && run && (!psc_en || at_term);
      end else begin : g_nopsc
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ restart ^ psc_en ^ (^ratio);
         assign adv = tick_en && run;
      end
   endgenerate
endmodule

// File: rtl/rtimer_cnt.sv
module rtimer_cnt #(
   parameter int COUNT_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cnt_we,
   input  logic [COUNT_W-1:0] cnt_wd,
   input  logic               reload_stb,
   input  logic [COUNT_W-1:0] ld_val,
   input  logic               adv,
   input  logic               auto_rl,
   output logic [COUNT_W-1:0] count,
   output logic [COUNT_W-1:0] nxt_adv,
   output logic               step,
   output logic               wrap
);
   localparam logic [COUNT_W-1:0] MAXV = {COUNT_W{1'b1}};

   assign step    = adv && !cnt_we && !reload_stb;
   assign wrap    = step && (count == MAXV);
   assign nxt_adv = (count == MAXV) ? (auto_rl ? ld_val : '0) : count + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (cnt_we) begin
         count <= cnt_wd;
      end else if (reload_stb) begin
         count <= ld_val;
      end else if (step) begin
         count <= nxt_adv;
      end
   end
endmodule

// File: rtl/rtimer_evt.sv
module rtimer_evt #(
   parameter int COUNT_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step,
   input  logic               wrap,
   input  logic [COUNT_W-1:0] nxt_adv,
   input  logic [COUNT_W-1:0] mat_val,
   input  logic               cmp_en,
   output logic               ovf_pulse,
   output logic               match_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_pulse   <= 1'b0;
         match_pulse <= 1'b0;
      end else begin
         ovf_pulse   <= wrap;
         match_pulse <= step && cmp_en && (nxt_adv == mat_val);
      end
   end
endmodule

// File: rtl/rtimer_top.sv
module rtimer_top
   import rtimer_pkg::*;
#(
   parameter int COUNT_W = 32,
   parameter bit HAS_PSC = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_en,
   input  logic               ctl_we,
   input  logic [CTL_W-1:0]   ctl_wd,
   input  logic               ld_we,
   input  logic [COUNT_W-1:0] ld_wd,
   input  logic               mat_we,
   input  logic [COUNT_W-1:0] mat_wd,
   input  logic               cnt_we,
   input  logic [COUNT_W-1:0] cnt_wd,
   input  logic               reload_stb,
   output logic [COUNT_W-1:0] count,
   output logic [CTL_W-1:0]   ctl_q,
   output logic               ovf_pulse,
   output logic               match_pulse
);
   generate
      if (COUNT_W < 2) begin : g_bad_w
         $error("rtimer_top: COUNT_W must be at least 2");
      end
      if ($bits(ctl_t) != CTL_W) begin : g_bad_ctl
         $error("rtimer_top: control struct width mismatch");
      end
   endgenerate

   ctl_t               ctl;
   logic [COUNT_W-1:0] ld_q;
   logic [COUNT_W-1:0] mat_q;
   logic [COUNT_W-1:0] nxt_adv;
   logic               adv;
   logic               step;
   logic               wrap;
   logic               psc_restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (ctl_we) begin
         ctl <= ctl_t'(ctl_wd);
      end else if (wrap && !ctl.reload) begin
         ctl.start <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_q  <= '0;
         mat_q <= '0;
      end else begin
         if (ld_we)  ld_q  <= ld_wd;
         if (mat_we) mat_q <= mat_wd;
      end
   end

   assign psc_restart = cnt_we || reload_stb || !ctl.start;

   rtimer_psc #(.RATIO_W(RATIO_W), .HAS_PSC(HAS_PSC)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .run     (ctl.start),
      .restart (psc_restart),
      .psc_en  (ctl.psc_en),
      .ratio   (ctl.ratio),
      .adv     (adv)
   );

   rtimer_cnt #(.COUNT_W(COUNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_we     (cnt_we),
      .cnt_wd     (cnt_wd),
      .reload_stb (reload_stb),
      .ld_val     (ld_q),
      .adv        (adv),
      .auto_rl    (ctl.reload),
      .count      (count),
      .nxt_adv    (nxt_adv),
      .step       (step),
      .wrap       (wrap)
   );

   rtimer_evt #(.COUNT_W(COUNT_W)) u_evt (
      .clk         (clk),
      .rst_n       (rst_n),
      .step        (step),
      .wrap        (wrap),
      .nxt_adv     (nxt_adv),
      .mat_val     (mat_q),
      .cmp_en      (ctl.cmp_en),
      .ovf_pulse   (ovf_pulse),
      .match_pulse (match_pulse)
   );

   assign ctl_q = CTL_W'(ctl);
endmodule

// File: rtl/rtimer_chk.sv
module rtimer_chk #(
   parameter int COUNT_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick_en,
   input logic               ctl_we,
   input logic               cnt_we,
   input logic [COUNT_W-1:0] cnt_wd,
   input logic               reload_stb,
   input logic [COUNT_W-1:0] ld_q,
   input logic [COUNT_W-1:0] mat_q,
   input logic [COUNT_W-1:0] count,
   input logic [6:0]         ctl_q,
   input logic               ovf_pulse,
   input logic               match_pulse
);
   localparam logic [COUNT_W-1:0] MAXV = {COUNT_W{1'b1}};

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[0] && tick_en && !ctl_q[5] && !cnt_we && !reload_stb && count != MAXV)
      |=> (count == $past(count) + 1'b1));

   p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !cnt_we && !reload_stb) |=> $stable(count));

   p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q[0] && !cnt_we && !reload_stb)
      |=> ($stable(count) && !ovf_pulse && !match_pulse));

   p_ovf_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_pulse && $past(ctl_q[1])) |-> (count == $past(ld_q)));

   p_ovf_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_pulse && !$past(ctl_q[1]) && !$past(ctl_we)) |-> (count == '0 && !ctl_q[0]));

   p_match_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse |-> ($past(ctl_q[6]) && count == $past(mat_q)));

   p_cnt_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> (count == $past(cnt_wd) && !ovf_pulse && !match_pulse));

   p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_stb && !cnt_we) |=> (count == $past(ld_q)));
endmodule

bind rtimer_top rtimer_chk #(.COUNT_W(COUNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_en     (tick_en),
   .ctl_we      (ctl_we),
   .cnt_we      (cnt_we),
   .cnt_wd      (cnt_wd),
   .reload_stb  (reload_stb),
   .ld_q        (ld_q),
   .mat_q       (mat_q),
   .count       (count),
   .ctl_q       (ctl_q),
   .ovf_pulse   (ovf_pulse),
   .match_pulse (match_pulse)
);

// File: tb/sim_rtimer_top.sv
module sim_rtimer_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] MAXV = 32'hFFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b1;
   logic        ctl_we = 1'b0;
   logic [6:0]  ctl_wd = '0;
   logic        ld_we = 1'b0;
   logic [31:0] ld_wd = '0;
   logic        mat_we = 1'b0;
   logic [31:0] mat_wd = '0;
   logic        cnt_we = 1'b0;
   logic [31:0] cnt_wd = '0;
   logic        reload_stb = 1'b0;
   logic [31:0] count;
   logic [6:0]  ctl_q;
   logic        ovf_pulse;
   logic        match_pulse;

   int n_chk  = 0;
   int n_fail = 0;
   int ovf_seen = 0;
   int mat_seen = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtimer_top u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .ctl_we(ctl_we), .ctl_wd(ctl_wd), .ld_we(ld_we), .ld_wd(ld_wd),
      .mat_we(mat_we), .mat_wd(mat_wd), .cnt_we(cnt_we), .cnt_wd(cnt_wd),
      .reload_stb(reload_stb), .count(count), .ctl_q(ctl_q),
      .ovf_pulse(ovf_pulse), .match_pulse(match_pulse)
   );

   always @(negedge clk) begin
      if (ovf_pulse)   ovf_seen++;
      if (match_pulse) mat_seen++;
   end

   // {psc_en, ratio[2:0], ticks[11:0], expected count[31:0]}
   localparam logic [47:0] VEC [6] = '{
      {1'b0, 3'd0, 12'd10,  32'd10},
      {1'b1, 3'd0, 12'd10,  32'd5},
      {1'b1, 3'd1, 12'd16,  32'd4},
      {1'b1, 3'd2, 12'd24,  32'd3},
      {1'b1, 3'd3, 12'd40,  32'd2},
      {1'b1, 3'd7, 12'd512, 32'd2}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctl(input logic [6:0] v);
      ctl_we = 1'b1; ctl_wd = v; cyc(1); ctl_we = 1'b0;
   endtask

   task automatic wr_ld(input logic [31:0] v);
      ld_we = 1'b1; ld_wd = v; cyc(1); ld_we = 1'b0;
   endtask

   task automatic wr_mat(input logic [31:0] v);
      mat_we = 1'b1; mat_wd = v; cyc(1); mat_we = 1'b0;
   endtask

   task automatic wr_cnt(input logic [31:0] v);
      cnt_we = 1'b1; cnt_wd = v; cyc(1); cnt_we = 1'b0;
   endtask

   // control and count written on the same edge
   task automatic launch(input logic [6:0] c, input logic [31:0] v);
      ctl_we = 1'b1; ctl_wd = c; cnt_we = 1'b1; cnt_wd = v;
      cyc(1);
      ctl_we = 1'b0; cnt_we = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int o0, m0;
      cyc(2);
      // R1 reset state
      chk("R1 count", count, 32'd0);
      chk("R1 ctl_q", {25'd0, ctl_q}, 32'd0);
      chk("R1 pulses", {30'd0, ovf_pulse, match_pulse}, 32'd0);
      rst_n = 1'b1;
      cyc(1);
      reload_stb = 1'b1; cnt_we = 1'b0; cyc(1); reload_stb = 1'b0;
      chk("R1 load zero", count, 32'd0);

      // R2 / R4 table of rate vectors
      for (int i = 0; i < 6; i++) begin
         launch({1'b0, VEC[i][47], VEC[i][46:44], 1'b0, 1'b1}, 32'd0);
         cyc(int'(VEC[i][43:32]));
         chk(VEC[i][47] ? "R4 prescaled rate" : "R2 full rate", count, VEC[i][31:0]);
         wr_ctl(7'h00);
      end

      // R11 control readback
      wr_ctl(7'h5A);
      chk("R11 ctl readback", {25'd0, ctl_q}, 32'h5A);
      wr_ctl(7'h00);

      // R3 hold while stopped
      wr_cnt(32'd100);
      o0 = ovf_seen; m0 = mat_seen;
      cyc(5);
      chk("R3 stopped hold", count, 32'd100);
      chk("R3 no events", ovf_seen - o0 + mat_seen - m0, 0);

      // R2 tick enable low
      launch(7'h01, 32'd200);
      tick_en = 1'b0;
      cyc(5);
      chk("R2 no tick hold", count, 32'd200);
      tick_en = 1'b1;
      cyc(1);
      chk("R2 tick resumes", count, 32'd201);
      wr_ctl(7'h00);

      // R5 overflow with auto-reload
      wr_ld(32'h55);
      launch(7'h03, MAXV - 32'd2);
      cyc(2);
      chk("R5 at max", count, MAXV);
      chk("R5 no early ovf", {31'd0, ovf_pulse}, 32'd0);
      cyc(1);
      chk("R5 reload value", count, 32'h55);
      chk("R5 ovf pulse", {31'd0, ovf_pulse}, 32'd1);
      chk("R5 start kept", {31'd0, ctl_q[0]}, 32'd1);
      cyc(1);
      chk("R5 pulse one cycle", {31'd0, ovf_pulse}, 32'd0);
      chk("R5 keeps counting", count, 32'h56);
      wr_ctl(7'h00);

      // R6 overflow without auto-reload
      launch(7'h01, MAXV - 32'd1);
      cyc(2);
      chk("R6 cleared", count, 32'd0);
      chk("R6 ovf pulse", {31'd0, ovf_pulse}, 32'd1);
      chk("R6 start cleared", {31'd0, ctl_q[0]}, 32'd0);
      cyc(3);
      chk("R6 stays stopped", count, 32'd0);

      // R7 match
      wr_mat(32'd20);
      launch(7'h41, 32'd15);
      cyc(4);
      chk("R7 before match", {31'd0, match_pulse}, 32'd0);
      cyc(1);
      chk("R7 match pulse", {31'd0, match_pulse}, 32'd1);
      chk("R7 match count", count, 32'd20);
      cyc(1);
      chk("R7 match one cycle", {31'd0, match_pulse}, 32'd0);
      wr_ctl(7'h00);
      m0 = mat_seen;
      launch(7'h01, 32'd15);
      cyc(10);
      chk("R7 compare disabled", mat_seen - m0, 0);
      wr_ctl(7'h00);

      // R8 both events together
      wr_ld(32'd7);
      wr_mat(32'd7);
      launch(7'h43, MAXV);
      cyc(1);
      chk("R8 both pulses", {30'd0, ovf_pulse, match_pulse}, 32'd3);
      chk("R8 count", count, 32'd7);
      wr_ctl(7'h00);

      // R9 reload strobe and write priority
      wr_ld(32'h1000);
      launch(7'h01, 32'd3);
      reload_stb = 1'b1; cyc(1); reload_stb = 1'b0;
      chk("R9 reload strobe", count, 32'h1000);
      reload_stb = 1'b1; cnt_we = 1'b1; cnt_wd = 32'h2222;
      cyc(1);
      reload_stb = 1'b0; cnt_we = 1'b0;
      chk("R9 write over reload", count, 32'h2222);
      wr_ctl(7'h00);

      // R10 prescaler restart on count write (divide by 4)
      launch(7'h25, 32'd0);
      cyc(2);
      wr_cnt(32'd50);
      cyc(3);
      chk("R10 phase restarted", count, 32'd50);
      cyc(1);
      chk("R10 first step", count, 32'd51);
      // R10 restart on stop
      cyc(2);
      wr_ctl(7'h24);
      wr_ctl(7'h25);
      cyc(3);
      chk("R10 stop restart", count, 32'd51);
      cyc(1);
      chk("R10 stop restart step", count, 32'd52);
      wr_ctl(7'h00);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule